// File: doc/BRIEF.md
# Triggered Waveform Parameter Sequencer

This block keeps a small table of waveform settings for a frequency synthesizer. Each entry is one set of three words: a frequency tuning word, an amplitude word and a phase word. An external trigger line, asynchronous to the block clock, steps through the table. Each rising edge of the trigger moves to the next entry. The block then offers that whole entry to the synthesizer write path as a single update request, using a valid/ready handshake.

Stepping happens only while the remote-mode input is high. In manual mode the trigger is ignored and the position in the table is kept. A loader port can rewrite entries, set the index of the last valid entry, and restart the sequence at entry zero. All of these work while the sequencer is running, without any reconfiguration. If a trigger edge arrives while the previous update is still waiting for the write path, it is held as a pending step and served as soon as the write path accepts. It is not lost.

Top module: `trig_param_seq`

## Requirements
- R1: While `rst_n` is low and after its release, `upd_valid` is 0. The next trigger issues entry 0, and the last valid index is DEPTH-1.
- R2: Timing of the first response. Suppose `trig_in` is low and then is first seen high at a rising clock edge E0, with `remote_en`=1 and no update outstanding. Then `upd_valid` is still 0 after edges E0 and E0+1, and is 1 after edge E0+2. At a clock of 15 MHz or more, this is well inside 200 ns.
- R3: Exactly one update is issued per low-to-high transition of `trig_in`. Holding the trigger high, or taking it low, issues nothing.
- R4: Successive updates carry the entries at indices 0, 1, 2 and onward up to the last valid index, then wrap to 0. `upd_index` reports the index of the entry that is presented.
- R5: While `upd_valid`=1 and `upd_ready`=0, the outputs `upd_valid`, `upd_index`, `upd_freq`, `upd_amp` and `upd_phase` stay unchanged. A transfer completes at a clock edge where both are 1.
- R6: A trigger edge that arrives while an update is outstanding is stored as one pending step. That step is issued at the edge where the outstanding transfer completes, so `upd_valid` stays 1 and shows the next entry.
- R7: While `remote_en`=0, trigger edges issue nothing, the table position does not move, and any pending step is discarded.
- R8: `ld_we` writes entry `ld_addr` at any time. An update always carries the table contents as they stood at the edge where the update was issued. If a write and an issue fall on the same edge, the update carries the old contents.
- R9: A `ld_done` pulse sets the table position to 0, so the next update carries entry 0. No update is issued at that edge. A trigger edge seen at that same edge is kept as pending.
- R10: `ld_len_we` loads `ld_last` as the last valid index, clamped to DEPTH-1. The new value governs wrapping from the following edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| remote_en | input | 1 | 1 = trigger-driven sequencing, 0 = manual (triggers ignored) |
| trig_in | input | 1 | Asynchronous external step trigger |
| ld_we | input | 1 | Table entry write strobe |
| ld_addr | input | AW | Entry index to write |
| ld_freq | input | FREQ_W | Frequency word to write |
| ld_amp | input | AMP_W | Amplitude word to write |
| ld_phase | input | PHASE_W | Phase word to write |
| ld_len_we | input | 1 | Strobe to load the last valid index |
| ld_last | input | AW | Last valid entry index |
| ld_done | input | 1 | Load-complete strobe; restarts the sequence at entry 0 |
| upd_ready | input | 1 | Synthesizer write path can accept an update |
| upd_valid | output | 1 | Update request present |
| upd_index | output | AW | Table index of the presented entry |
| upd_freq | output | FREQ_W | Frequency word of the update |
| upd_amp | output | AMP_W | Amplitude word of the update |
| upd_phase | output | PHASE_W | Phase word of the update |

## Verification
The bench targets these corner cases:
- Exact trigger-to-request latency. A wrong synchronizer depth would move the request one cycle early or late.
- A trigger held high for a long time. Level-sensitive logic would issue a burst of updates instead of one.
- Triggers during a stalled handshake. Dropping the pending step would lose an update, and overwriting a held request would break R5.
- Wrapping with a shortened length, a restart through `ld_done`, and a table write while running. An off-by-one limit, a missed pointer reset, or a stale read copy would each issue the wrong entry.
- Triggers in manual mode. A missing mode gate would move the position that the next remote step uses.

// File: rtl/trig_param_seq_pkg.sv
package trig_param_seq_pkg;
  parameter int FREQ_W  = 32;
  parameter int AMP_W   = 14;
  parameter int PHASE_W = 14;

  typedef struct packed {
    logic [FREQ_W-1:0]  freq;
    logic [AMP_W-1:0]   amp;
    logic [PHASE_W-1:0] phase;
  } wave_set_t;

  localparam int SET_W = $bits(wave_set_t);
endpackage

// File: rtl/trig_sync_edge.sv
module trig_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  // synchronizer chain
  always_comb begin
    sync_d[0] = async_i;
    for (int i = 1; i < STAGES; i++) sync_d[i] = sync_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/param_table.sv
module param_table
  import trig_param_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  wave_set_t     wr_data,
  input  logic [AW-1:0] rd_addr,
  output wave_set_t     rd_data
);
  wave_set_t mem_q [DEPTH];

  // storage array: no reset, written only by the loader
  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/step_ctrl.sv
module step_ctrl
  import trig_param_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          remote_en,
  input  logic          edge_i,
  input  logic          restart_i,
  input  logic          len_we_i,
  input  logic [AW-1:0] len_last_i,
  input  wave_set_t     rd_data_i,
  input  logic          out_ready_i,
  output logic [AW-1:0] idx_o,
  output logic          pend_o,
  output logic          out_valid_o,
  output logic [AW-1:0] out_index_o,
  output wave_set_t     out_data_o
);
  localparam logic [AW-1:0] LAST_MAX = AW'(DEPTH - 1);

  logic [AW-1:0] idx_q, idx_d;
  logic [AW-1:0] last_q, last_d;
  logic          pend_q, pend_d;
  logic          valid_q, valid_d;
  logic [AW-1:0] oidx_q;
  wave_set_t     odata_q;
  logic          slot_free, want, fire;

  always_comb begin
    slot_free = !valid_q || out_ready_i;
    want      = remote_en && !restart_i && (edge_i || pend_q);
    fire      = want && slot_free;

    if (fire)             valid_d = 1'b1;
    else if (out_ready_i) valid_d = 1'b0;
    else                  valid_d = valid_q;

    if (!remote_en) pend_d = 1'b0;
    else if (fire)  pend_d = edge_i && pend_q;
    else            pend_d = pend_q || edge_i;

    if (restart_i)            idx_d = '0;
    else if (fire)            idx_d = (idx_q >= last_q) ? '0 : idx_q + 1'b1;
    else                      idx_d = idx_q;

    if (len_we_i) last_d = (len_last_i > LAST_MAX) ? LAST_MAX : len_last_i;
    else          last_d = last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      last_q  <= LAST_MAX;
      pend_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      idx_q   <= idx_d;
      last_q  <= last_d;
      pend_q  <= pend_d;
      valid_q <= valid_d;
    end
  end

  // update payload, loaded only when a step is issued
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oidx_q  <= '0;
      odata_q <= '0;
    end else if (fire) begin
      oidx_q  <= idx_q;
      odata_q <= rd_data_i;
    end
  end

  assign idx_o       = idx_q;
  assign pend_o      = pend_q;
  assign out_valid_o = valid_q;
  assign out_index_o = oidx_q;
  assign out_data_o  = odata_q;
endmodule

// File: rtl/trig_param_seq.sv
module trig_param_seq
  import trig_param_seq_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               remote_en,
  input  logic               trig_in,
  input  logic               ld_we,
  input  logic [AW-1:0]      ld_addr,
  input  logic [FREQ_W-1:0]  ld_freq,
  input  logic [AMP_W-1:0]   ld_amp,
  input  logic [PHASE_W-1:0] ld_phase,
  input  logic               ld_len_we,
  input  logic [AW-1:0]      ld_last,
  input  logic               ld_done,
  input  logic               upd_ready,
  output logic               upd_valid,
  output logic [AW-1:0]      upd_index,
  output logic [FREQ_W-1:0]  upd_freq,
  output logic [AMP_W-1:0]   upd_amp,
  output logic [PHASE_W-1:0] upd_phase
);
  logic          trig_edge;
  logic          pend_flag;
  logic [AW-1:0] next_idx;
  wave_set_t     wr_set, rd_set, out_set;

  assign wr_set = '{freq: ld_freq, amp: ld_amp, phase: ld_phase};

  trig_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (trig_in),
    .rise_o  (trig_edge)
  );

  param_table #(.DEPTH(DEPTH), .AW(AW)) u_table (
    .clk     (clk),
    .wr_en   (ld_we),
    .wr_addr (ld_addr),
    .wr_data (wr_set),
    .rd_addr (next_idx),
    .rd_data (rd_set)
  );

  step_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .remote_en   (remote_en),
    .edge_i      (trig_edge),
    .restart_i   (ld_done),
    .len_we_i    (ld_len_we),
    .len_last_i  (ld_last),
    .rd_data_i   (rd_set),
    .out_ready_i (upd_ready),
    .idx_o       (next_idx),
    .pend_o      (pend_flag),
    .out_valid_o (upd_valid),
    .out_index_o (upd_index),
    .out_data_o  (out_set)
  );

  assign upd_freq  = out_set.freq;
  assign upd_amp   = out_set.amp;
  assign upd_phase = out_set.phase;
endmodule

// File: rtl/trig_param_seq_chk.sv
module trig_param_seq_chk #(
  parameter int AW = 4,
  parameter int DW = 60
) (
  input logic          clk,
  input logic          rst_n,
  input logic          remote_en,
  input logic          ld_done,
  input logic          upd_ready,
  input logic          upd_valid,
  input logic [AW-1:0] upd_index,
  input logic [DW-1:0] upd_word,
  input logic          trig_edge,
  input logic          pend_flag,
  input logic [AW-1:0] next_idx
);
  // R5: a stalled request holds still
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && !upd_ready |=> upd_valid && $stable(upd_index) && $stable(upd_word));

  // R7: a new request only appears if remote mode was on
  a_r7_remote_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_valid) |-> $past(remote_en));

  // R3: every new request has a trigger edge or pending step behind it
  a_r3_issue_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && (!$past(upd_valid) || $past(upd_ready))) |-> $past(trig_edge || pend_flag));

  // R6: an edge that cannot be served is remembered
  a_r6_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
    trig_edge && remote_en && !ld_done && upd_valid && !upd_ready |=> pend_flag);

  // R9: load-complete restarts at entry zero
  a_r9_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |=> next_idx == '0);
endmodule

bind trig_param_seq trig_param_seq_chk #(
  .AW (AW),
  .DW (trig_param_seq_pkg::SET_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .remote_en (remote_en),
  .ld_done   (ld_done),
  .upd_ready (upd_ready),
  .upd_valid (upd_valid),
  .upd_index (upd_index),
  .upd_word  (out_set),
  .trig_edge (trig_edge),
  .pend_flag (pend_flag),
  .next_idx  (next_idx)
);

// File: tb/trig_param_seq_bench.sv
module trig_param_seq_bench;
  import trig_param_seq_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic remote_en, trig_in, ld_we, ld_len_we, ld_done, upd_ready;
  logic [AW-1:0] ld_addr, ld_last;
  logic [FREQ_W-1:0] ld_freq;
  logic [AMP_W-1:0] ld_amp;
  logic [PHASE_W-1:0] ld_phase;
  logic upd_valid;
  logic [AW-1:0] upd_index;
  logic [FREQ_W-1:0] upd_freq;
  logic [AMP_W-1:0] upd_amp;
  logic [PHASE_W-1:0] upd_phase;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_param_seq #(.DEPTH(DEPTH)) u_trig_param_seq (
    .clk, .rst_n, .remote_en, .trig_in, .ld_we, .ld_addr, .ld_freq, .ld_amp,
    .ld_phase, .ld_len_we, .ld_last, .ld_done, .upd_ready, .upd_valid,
    .upd_index, .upd_freq, .upd_amp, .upd_phase
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p, input logic [AW-1:0] last);
    return (p >= last) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [AW-1:0] clamp_last(input logic [AW-1:0] v);
    return (int'(v) > DEPTH - 1) ? AW'(DEPTH - 1) : v;
  endfunction

  // reference model, updated one time unit after each rising edge
  logic [SET_W-1:0] ref_tab [DEPTH];
  logic [AW-1:0] exp_ptr, ref_last, last_idx;
  logic [SET_W-1:0] last_word, held_word;
  logic [AW-1:0] held_idx;
  logic pv;
  int iss_cnt;

  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      exp_ptr = '0; ref_last = AW'(DEPTH - 1); pv = 1'b0; iss_cnt = 0;
    end else begin
      if (pv && !upd_ready) begin
        // R5: stalled request unchanged
        chk(upd_valid && upd_index == held_idx && {upd_freq, upd_amp, upd_phase} == held_word,
            "R5 hold", {upd_index, upd_freq}, {held_idx, held_word[SET_W-1 -: FREQ_W]});
      end else if (upd_valid) begin
        // R4/R8: new request carries the expected entry
        chk(upd_index == exp_ptr && {upd_freq, upd_amp, upd_phase} == ref_tab[exp_ptr],
            "R4 entry", {upd_index, upd_freq}, {exp_ptr, ref_tab[exp_ptr][SET_W-1 -: FREQ_W]});
        last_idx = upd_index;
        last_word = {upd_freq, upd_amp, upd_phase};
        exp_ptr = next_ptr(exp_ptr, ref_last);
        iss_cnt++;
      end
      pv = upd_valid;
      held_idx = upd_index;
      held_word = {upd_freq, upd_amp, upd_phase};
      if (ld_we) ref_tab[ld_addr] = {ld_freq, ld_amp, ld_phase};
      if (ld_done) exp_ptr = '0;
      if (ld_len_we) ref_last = clamp_last(ld_last);
    end
  end

  // ready driver: random with stalls of at most two cycles
  bit rnd_ready = 1'b0;
  int stall_run = 0;
  always @(negedge clk) begin
    if (rnd_ready) begin
      if (stall_run >= 2 || ($urandom % 4) != 0) begin
        upd_ready = 1'b1; stall_run = 0;
      end else begin
        upd_ready = 1'b0; stall_run++;
      end
    end
  end

  task automatic pulse(input int hi, input int lo);
    @(negedge clk); trig_in = 1'b1;
    repeat (hi) @(negedge clk);
    trig_in = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic write_entry(input logic [AW-1:0] a, input logic [SET_W-1:0] w);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = a; {ld_freq, ld_amp, ld_phase} = w;
    @(negedge clk); ld_we = 1'b0;
  endtask

  task automatic set_len_restart(input logic [AW-1:0] last);
    @(negedge clk); ld_len_we = 1'b1; ld_last = last; ld_done = 1'b1;
    @(negedge clk); ld_len_we = 1'b0; ld_done = 1'b0;
  endtask

  function automatic logic [SET_W-1:0] rnd_set();
    return {$urandom, 28'($urandom)};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'd4242));
    rst_n = 1'b0; remote_en = 1'b1; trig_in = 1'b0; ld_we = 1'b0; ld_len_we = 1'b0;
    ld_done = 1'b0; upd_ready = 1'b1; ld_addr = '0; ld_last = '0;
    ld_freq = '0; ld_amp = '0; ld_phase = '0;
    repeat (3) @(negedge clk);
    chk(upd_valid == 1'b0, "R1 reset valid", upd_valid, 0);
    rst_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) write_entry(AW'(i), rnd_set());
    repeat (3) @(negedge clk);
    chk(upd_valid == 1'b0 && iss_cnt == 0, "R1 idle after reset", iss_cnt, 0);

    // R2 latency: trig seen at E0, valid after E0+2
    @(negedge clk); trig_in = 1'b1;
    @(posedge clk); @(posedge clk); #2;
    chk(upd_valid == 1'b0, "R2 not early", upd_valid, 0);
    @(posedge clk); #2;
    chk(upd_valid == 1'b1 && upd_index == 0, "R2 latency", {upd_valid, upd_index}, {1'b1, 4'd0});
    @(negedge clk); trig_in = 1'b0;
    repeat (6) @(negedge clk);

    // R3: long high level gives one update
    base = iss_cnt;
    pulse(30, 10);
    chk(iss_cnt == base + 1, "R3 level", iss_cnt, base + 1);

    // R7: manual mode ignores triggers and keeps position
    base = iss_cnt;
    @(negedge clk); remote_en = 1'b0;
    pulse(3, 8); pulse(3, 8); pulse(3, 8);
    chk(iss_cnt == base && upd_valid == 1'b0, "R7 manual", iss_cnt, base);
    @(negedge clk); remote_en = 1'b1;
    pulse(3, 8);
    chk(iss_cnt == base + 1 && last_idx == 2, "R7 position kept", last_idx, 2);

    // R6: trigger during stall becomes pending
    base = iss_cnt;
    @(negedge clk); upd_ready = 1'b0;
    pulse(3, 8);
    pulse(3, 8);
    chk(iss_cnt == base + 1 && upd_valid, "R6 first held", iss_cnt, base + 1);
    @(negedge clk); upd_ready = 1'b1;
    @(posedge clk); #2;
    chk(upd_valid == 1'b1 && upd_index == 4, "R6 pending served", upd_index, 4);
    repeat (4) @(negedge clk);
    chk(iss_cnt == base + 2, "R6 count", iss_cnt, base + 2);

    // R10: shortened length wraps at index 2
    set_len_restart(4'd2);
    base = iss_cnt;
    for (int i = 0; i < 5; i++) pulse(3, 8);
    chk(iss_cnt == base + 5 && last_idx == 1, "R10 wrap", last_idx, 1);

    // R9: restart sends next step to entry zero
    set_len_restart(4'd15);
    pulse(3, 8);
    chk(last_idx == 0, "R9 restart", last_idx, 0);

    // R8: rewrite entry 3 while running, then reach it
    begin
      logic [SET_W-1:0] nw;
      nw = rnd_set();
      pulse(3, 8);
      write_entry(4'd3, nw);
      pulse(3, 8); pulse(3, 8);
      chk(last_idx == 3 && last_word == nw, "R8 live write", last_word[SET_W-1 -: FREQ_W], nw[SET_W-1 -: FREQ_W]);
    end

    // random phase with random ready stalls
    base = iss_cnt;
    rnd_ready = 1'b1;
    for (int i = 0; i < 60; i++) begin
      if (($urandom % 10) == 0) set_len_restart(AW'($urandom));
      pulse(2 + int'($urandom % 3), 8 + int'($urandom % 8));
    end
    repeat (10) @(negedge clk);
    rnd_ready = 1'b0; upd_ready = 1'b1;
    chk(iss_cnt == base + 60, "R3 random count", iss_cnt, base + 60);

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule